// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a 64-bit up-counter reached through a small 32-bit register bus. Software loads a 64-bit terminal value as two data words and picks a clock divider and a run mode. It then issues a start command. The counter advances once per divided clock period. When it meets the terminal value, it either wraps to zero (continuous) or freezes there (one-shot). If the terminal value is all ones and the mode is continuous, the block is a free-running 64-bit time base.

The counter is read as two words. Reading the low word returns the live low half and also copies the live high half into a holding register. Reading the high word returns that holding register. A low-then-high read pair therefore always gives one coherent 64-bit sample, however long software waits between the two accesses. The data width is a parameter, and the counter is always two data words wide.

Top module: `interval_timer64`

## Requirements
- R1: After reset, every register reads zero and the counter does not advance until a start command is written.
- R2: Writing 1 to control bit 0 (offset 0x00) clears the counter and the divider and starts counting. With divider field N in mode bits 11:8 (offset 0x04), the counter advances by one every N+1 clock cycles.
- R3: With mode bit 0 set (continuous), the next advance after the counter equals the period wraps the counter to zero.
- R4: With mode bit 0 clear (one-shot), the counter stops at the period value and stays there until the next start command.
- R5: A read of offset 0x20 returns counter bits [DW-1:0] and captures counter bits [2DW-1:DW] into a holding register. A read of offset 0x24 returns that holding register, whatever delay separates the two reads.
- R6: A read of offset 0x24 with no new low-word read returns the last captured value, which is zero after reset.
- R7: Writing 1 to control bit 8 clears the counter, the divider, the holding register, the mode and both period words, and leaves the timer stopped. It wins over a start command in the same write.
- R8: Offset 0x04 reads back bit 0 and bits 11:8 as last written, and all other bits read zero. Offset 0x08 holds period bits [DW-1:0] and offset 0x0C holds bits [2DW-1:DW]; both read back as written.
- R9: Writes to 0x20 and 0x24 have no effect. Reads of 0x00 and of unmapped offsets return zero.
- R10: Read data is registered: it appears on the clock edge that samples the read enable and holds until the next read.
- R11: With period all ones and continuous mode, the low word carries into the high word as a single 2DW-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | DATA_W | Registered read data |

## Verification
A start write sampled on edge E0 makes the counter equal floor(k/(N+1)) after edge E0+k. A read sampled on edge R therefore returns that value for k = R-1-E0, wrapped modulo period+1 in continuous mode and clamped to the period in one-shot mode. The bench records the edge number of every bus access and samples read data at the falling edge that follows it. It derives each expected count from those edge numbers alone. The divider sweep covers all sixteen divider values, and the coherence check places a long delay across a high-word carry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_MODE   = 'h04;
  localparam int OFS_PER_LO = 'h08;
  localparam int OFS_PER_HI = 'h0C;
  localparam int OFS_CNT_LO = 'h20;
  localparam int OFS_CNT_HI = 'h24;

  localparam int START_BIT = 0;
  localparam int SWRST_BIT = 8;
  localparam int CONT_BIT  = 0;
  localparam int PRE_LSB   = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_PER_LO, SEL_PER_HI, SEL_CNT_LO, SEL_CNT_HI
  } rdSel_e;

  typedef struct packed {
    logic   startCmd;
    logic   swReset;
    logic   wrMode;
    logic   wrPerLo;
    logic   wrPerHi;
    logic   rdStrobe;
    logic   capHigh;
    rdSel_e rdSel;
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              startBit,
  input  logic              swRstBit,
  input  logic              rdEn,
  output tmrStrobes_t       strobes
);
  always_comb begin
    strobes       = '0;
    strobes.rdSel = SEL_NONE;
    if (wrEn) begin
      if (addr == ADDR_W'(OFS_CTRL)) begin
        strobes.startCmd = startBit;
        strobes.swReset  = swRstBit;
      end
      if (addr == ADDR_W'(OFS_MODE))   strobes.wrMode  = 1'b1;
      if (addr == ADDR_W'(OFS_PER_LO)) strobes.wrPerLo = 1'b1;
      if (addr == ADDR_W'(OFS_PER_HI)) strobes.wrPerHi = 1'b1;
    end
    if (rdEn) begin
      strobes.rdStrobe = 1'b1;
      if (addr == ADDR_W'(OFS_MODE))   strobes.rdSel = SEL_MODE;
      if (addr == ADDR_W'(OFS_PER_LO)) strobes.rdSel = SEL_PER_LO;
      if (addr == ADDR_W'(OFS_PER_HI)) strobes.rdSel = SEL_PER_HI;
      if (addr == ADDR_W'(OFS_CNT_LO)) begin
        strobes.rdSel   = SEL_CNT_LO;
        strobes.capHigh = 1'b1;
      end
      if (addr == ADDR_W'(OFS_CNT_HI)) strobes.rdSel = SEL_CNT_HI;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int CNT_W = 2 * DATA_W;

  logic              contMode;
  logic [PRE_W-1:0]  preVal;
  logic [PRE_W-1:0]  preCnt;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  counter;
  logic [DATA_W-1:0] holdHi;
  logic              running;
  logic              tick;
  logic              atPeriod;
  logic [DATA_W-1:0] modeWord;

  assign tick     = running && (preCnt == preVal);
  assign atPeriod = (counter == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contMode <= 1'b0;
      preVal   <= '0;
    end else if (strobes.swReset) begin
      contMode <= 1'b0;
      preVal   <= '0;
    end else if (strobes.wrMode) begin
      contMode <= wrData[CONT_BIT];
      preVal   <= wrData[PRE_LSB +: PRE_W];
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_perHalf
    logic              wrThis;
    logic [DATA_W-1:0] word;
    assign wrThis = (h == 0) ? strobes.wrPerLo : strobes.wrPerHi;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                word <= '0;
      else if (strobes.swReset) word <= '0;
      else if (wrThis)          word <= wrData;
    end
    assign period[h*DATA_W +: DATA_W] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter <= '0;
      preCnt  <= '0;
      running <= 1'b0;
    end else if (strobes.swReset) begin
      counter <= '0;
      preCnt  <= '0;
      running <= 1'b0;
    end else if (strobes.startCmd) begin
      counter <= '0;
      preCnt  <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (tick) begin
        preCnt <= '0;
        if (atPeriod) begin
          if (contMode) counter <= '0;
          else          running <= 1'b0;
        end else begin
          counter <= counter + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdHi <= '0;
    else if (strobes.swReset) holdHi <= '0;
    else if (strobes.capHigh) holdHi <= counter[CNT_W-1:DATA_W];
  end

  always_comb begin
    modeWord                     = '0;
    modeWord[CONT_BIT]           = contMode;
    modeWord[PRE_LSB +: PRE_W]   = preVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdStrobe) begin
      case (strobes.rdSel)
        SEL_MODE:   rdData <= modeWord;
        SEL_PER_LO: rdData <= period[DATA_W-1:0];
        SEL_PER_HI: rdData <= period[CNT_W-1:DATA_W];
        SEL_CNT_LO: rdData <= counter[DATA_W-1:0];
        SEL_CNT_HI: rdData <= holdHi;
        default:    rdData <= '0;
      endcase
    end
  end

  // Counter moves only on a divided tick or a command
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobes.startCmd && !strobes.swReset) |=> $stable(counter));

  assert_wrap_cont_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && atPeriod && contMode && !strobes.startCmd && !strobes.swReset)
      |=> (counter == '0) && running);

  assert_stop_oneshot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && atPeriod && !contMode && !strobes.startCmd && !strobes.swReset)
      |=> !running && $stable(counter));

  assert_holding_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capHigh && !strobes.swReset) |=> $stable(holdHi));

  assert_swreset_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swReset |=> (counter == '0) && !running && (holdHi == '0) && (period == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdSel == SEL_NONE) |=> (rdData == '0));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData
);
  tmrStrobes_t strobes;

  tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr     (busAddr),
    .wrEn     (busWrEn),
    .startBit (busWrData[START_BIT]),
    .swRstBit (busWrData[SWRST_BIT]),
    .rdEn     (busRdEn),
    .strobes  (strobes)
  );

  tmr_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .rdData  (busRdData)
  );
endmodule

// File: tb/interval_timer64_bench.sv
module interval_timer64_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic          busRdEn = 1'b0;
  logic [DW-1:0] busRdData;

  longint edgeNo = 0;
  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  interval_timer64 #(.ADDR_W(8), .DATA_W(DW), .PRE_W(4)) u_interval_timer64 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData)
  );

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input longint d, output longint e);
    busAddr = a; busWrData = DW'(d); busWrEn = 1'b1;
    @(negedge clk);
    e = edgeNo;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output longint d, output longint e);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = longint'(busRdData);
    e = edgeNo;
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint expCnt(longint r, longint e0, longint n, longint p, bit cont);
    longint t;
    t = (r - 1 - e0) / (n + 1);
    if (cont) return t % (p + 1);
    return (t > p) ? p : t;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    longint d, e, e0, r, k, hiCap;
    longint ones = 64'h0000_0000_FFFF_FFFF;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 / R6 / R9: everything reads zero after reset
    busRead(8'h00, d, e); check("R1 ctrl", d, 0);
    busRead(8'h04, d, e); check("R1 mode", d, 0);
    busRead(8'h08, d, e); check("R1 perLo", d, 0);
    busRead(8'h0C, d, e); check("R1 perHi", d, 0);
    idle(10);
    busRead(8'h20, d, e); check("R1 cntLo stays zero", d, 0);
    busRead(8'h24, d, e); check("R6 hold zero", d, 0);

    // R8 readback
    busWrite(8'h04, 'h0301, e); busRead(8'h04, d, e); check("R8 mode", d, 'h0301);
    busWrite(8'h04, 'hFFFF, e); busRead(8'h04, d, e); check("R8 mode bits", d, 'h0F01);
    busWrite(8'h08, 'h1234, e); busWrite(8'h0C, 'h00AB, e);
    busRead(8'h08, d, e); check("R8 perLo", d, 'h1234);
    busRead(8'h0C, d, e); check("R8 perHi", d, 'h00AB);

    // R9 ignored writes and zero reads
    busWrite(8'h20, 'h5555, e); busWrite(8'h24, 'hAAAA, e);
    busRead(8'h20, d, e); check("R9 cnt write ignored", d, 0);
    busRead(8'h24, d, e); check("R9 hold write ignored", d, 0);
    busRead(8'h10, d, e); check("R9 unmapped", d, 0);
    busRead(8'h00, d, e); check("R9 ctrl reads zero", d, 0);

    // R10: data holds with no read
    busRead(8'h08, d, e); idle(4); check("R10 hold", longint'(busRdData), 'h1234);

    // R7 software reset
    busWrite(8'h00, 'h100, e);
    busRead(8'h04, d, e); check("R7 mode cleared", d, 0);
    busRead(8'h08, d, e); check("R7 perLo cleared", d, 0);
    busRead(8'h0C, d, e); check("R7 perHi cleared", d, 0);

    // R2 divider sweep, free-running period
    for (int n = 0; n < 16; n++) begin
      busWrite(8'h00, 'h100, e);
      busWrite(8'h04, (n << 8) | 1, e);
      busWrite(8'h08, 'hFFFF, e);
      busWrite(8'h0C, 'hFFFF, e);
      busWrite(8'h00, 'h1, e0);
      idle(3 * n + 5 + (n % 3));
      busRead(8'h20, d, r); check("R2 divided count", d, expCnt(r, e0, n, ones, 1) & 'hFFFF);
      idle(n);
      busRead(8'h20, d, r); check("R2 divided count later", d, expCnt(r, e0, n, ones, 1) & 'hFFFF);
      busRead(8'h24, d, r); check("R5 high zero", d, 0);
    end

    // R3 continuous wrap with period 5, divider 2
    busWrite(8'h00, 'h100, e);
    busWrite(8'h04, (1 << 8) | 1, e);
    busWrite(8'h08, 5, e);
    busWrite(8'h00, 'h1, e0);
    for (int i = 0; i < 30; i++) begin
      busRead(8'h20, d, r); check("R3 wrap", d, expCnt(r, e0, 1, 5, 1));
    end

    // R4 one-shot, period 7, divider 1
    busWrite(8'h00, 'h100, e);
    busWrite(8'h08, 7, e);
    busWrite(8'h00, 'h1, e0);
    for (int i = 0; i < 20; i++) begin
      busRead(8'h20, d, r); check("R4 oneshot", d, expCnt(r, e0, 0, 7, 0));
    end
    idle(50);
    busRead(8'h20, d, r); check("R4 held", d, 7);
    busWrite(8'h00, 'h1, e0);
    idle(2);
    busRead(8'h20, d, r); check("R4 restart", d, expCnt(r, e0, 0, 7, 0));

    // R7 reset wins over start
    busWrite(8'h00, 'h101, e);
    idle(10);
    busRead(8'h20, d, r); check("R7 reset over start", d, 0);

    // R5 / R6 / R11 coherent read across a carry
    busWrite(8'h04, 1, e);
    busWrite(8'h08, 'hFFFF, e);
    busWrite(8'h0C, 'hFFFF, e);
    busWrite(8'h00, 'h1, e0);
    idle('hFFE0);
    busRead(8'h20, d, r);
    k = r - 1 - e0;
    hiCap = (k >> DW) & 'hFFFF;
    check("R5 low word", d, k & 'hFFFF);
    idle(100);
    busRead(8'h24, d, r); check("R5 captured high", d, hiCap);
    busRead(8'h24, d, r); check("R6 repeat high", d, hiCap);
    busRead(8'h20, d, r);
    k = r - 1 - e0;
    check("R11 low after carry", d, k & 'hFFFF);
    busRead(8'h24, d, r); check("R11 high after carry", d, (k >> DW) & 'hFFFF);
    check("R11 carry happened", (k >> DW), 1);

    finishRun();
  end
endmodule